// File: doc/BRIEF.md
# Outstanding Miss and Write Buffer Allocator

This block keeps track of the memory requests a cache has sent out and not yet finished. It has two small pools of entries. The miss pool holds cacheable misses and uncacheable reads. The write pool holds writes. A requester offers an allocation of one of three kinds on a valid/ready port. The block chooses the target pool and stores the address and size in the form that kind needs. It stamps the entry with an order number taken from a single counter shared by both pools. If asked, it raises a memory-side bus request tagged with the pool as its cause.

A pool counts as saturated when every one of its entries is allocated and none has yet been marked as in service. The allocation that saturates a pool sets that pool's bit in a stall mask. The OR of the mask bits stalls the CPU side. Only a mark-in-service that takes the pool out of saturation clears the bit. Entries are released by a separate free command. Per-cause counters record how many stall episodes occurred and how many cycles they lasted. A miss counter raises a terminal flag when it reaches a configured limit.

Back-pressure rules for the allocation port:
- `alloc_ready` depends only on `alloc_kind` and on the pool state. It never depends on `alloc_valid`, so it may be probed with `alloc_valid` low.
- A transfer happens on a rising edge where both `alloc_valid` and `alloc_ready` are high.
- A requester that sees `alloc_ready` low may hold or withdraw its request. A refused offer leaves no trace in the block.

Top module: `miss_wb_alloc`

## Requirements
- R1: After synchronous reset, both pools are empty, the stall mask, order number, miss counter and all statistics are zero, and `alloc_ready` is high for kinds 0, 1 and 2.
- R2: Kind 0 (cacheable miss) goes to the miss pool (pool 0). The stored address is the offered address with its low log2(BLK_BYTES) bits cleared, and the stored size is BLK_BYTES.
- R3: Kind 1 (write) goes to the write pool (pool 1). The stored address and size equal the offered ones.
- R4: Kind 2 (uncacheable read) goes to pool 0 with its exact address and size. Kind 3 is never accepted (`alloc_ready` stays low).
- R5: Each accepted allocation stores the current order number, and the order number then rises by one. One counter serves both pools.
- R6: `alloc_ready` is low when the target pool has no unallocated entry. An offer refused this way changes no entry, no counter and no order number.
- R7: An allocation that leaves its pool with all entries allocated and none in service sets mask bit (1 << pool) at that edge. `cpu_stall` is the OR of the mask bits.
- R8: Marking an entry in service clears its pool's mask bit only if the pool was saturated before the mark and is not saturated after it. A mark aimed at an entry that is free or already in service has no effect.
- R9: In the cycle after an accepted allocation, `bus_req_valid` is high for one cycle with `bus_req_cause` equal to the pool index. This happens only if `alloc_want_bus` was high and `retry_wait` was low.
- R10: Each mask-bit set adds one to that cause's event counter and stamps the cycle. Each clear adds the number of clock edges since that stamp to that cause's blocked-cycle total.
- R11: The miss counter counts accepted kind-0 allocations and saturates at MAX_MISSES. `miss_limit` goes high once the counter equals MAX_MISSES and stays high until reset.
- R12: Freeing an allocated entry makes it unallocated. A new allocation receives the lowest-numbered unallocated entry of its pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocation offer present |
| alloc_ready | output | 1 | Target pool can take the offer |
| alloc_kind | input | 2 | 0 cacheable miss, 1 write, 2 uncacheable read, 3 none |
| alloc_addr | input | AW | Offered address |
| alloc_size | input | SIZE_W | Offered size in bytes |
| alloc_want_bus | input | 1 | Ask for a memory-side bus request |
| grant_idx | output | IW | Entry index the offer would receive |
| grant_order | output | ORD_W | Order number the offer would receive |
| retry_wait | input | 1 | Memory-side port waits on a retry |
| bus_req_valid | output | 1 | Memory-side bus request pulse |
| bus_req_cause | output | 1 | Pool that caused the request |
| svc_valid | input | 1 | Mark an entry in service |
| svc_pool | input | 1 | Pool of the entry to mark |
| svc_idx | input | IW | Index of the entry to mark |
| free_valid | input | 1 | Release an entry |
| free_pool | input | 1 | Pool of the entry to release |
| free_idx | input | IW | Index of the entry to release |
| peek_pool | input | 1 | Pool to inspect |
| peek_idx | input | IW | Entry to inspect |
| peek_valid | output | 1 | Inspected entry is allocated |
| peek_inserv | output | 1 | Inspected entry is in service |
| peek_addr | output | AW | Stored address |
| peek_size | output | SIZE_W | Stored size |
| peek_order | output | ORD_W | Stored order number |
| stall_mask | output | 2 | Per-pool stall bits |
| cpu_stall | output | 1 | CPU-side stall |
| stat_sel | input | 1 | Cause whose statistics are shown |
| stat_events | output | CNT_W | Stall episodes for that cause |
| stat_cycles | output | CNT_W | Blocked cycles for that cause |
| miss_count | output | CNT_W | Accepted cacheable misses |
| miss_limit | output | 1 | Miss limit reached |

## Verification
`alloc_ready`, `grant_idx` and `grant_order` are combinational. The bench samples them one time step after it drives an offer and before the clock edge. Entry contents, the stall mask, the statistics and the miss counter change at the accepting edge, so the bench reads them at the following falling edge. `bus_req_valid` is registered and is checked at that same falling edge, which is the only cycle in which it is high. For blocked-cycle totals, the bench counts rising edges between the saturating allocation and the mark-in-service, and compares that count with the statistic.

// File: rtl/mwa_pkg.sv
package mwa_pkg;
  typedef enum logic [1:0] {
    KIND_MISS  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_UNCRD = 2'd2,
    KIND_NONE  = 2'd3
  } alloc_kind_e;

  localparam int POOL_MISS = 0;
  localparam int POOL_WR   = 1;
  localparam int NUM_POOLS = 2;
endpackage

// File: rtl/mwa_entry_pool.sv
module mwa_entry_pool #(
  parameter int DEPTH  = 4,
  parameter int AW     = 16,
  parameter int SIZE_W = 8,
  parameter int ORD_W  = 8,
  parameter int IW     = 2,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [AW-1:0]     alloc_addr,
  input  logic [SIZE_W-1:0] alloc_size,
  input  logic [ORD_W-1:0]  alloc_ord,
  input  logic              svc_en,
  input  logic [IW-1:0]     svc_idx,
  input  logic              free_en,
  input  logic [IW-1:0]     free_idx,
  input  logic [IW-1:0]     peek_idx,
  output logic              has_slot,
  output logic [IW-1:0]     slot_idx,
  output logic [CW-1:0]     pend_cnt,
  output logic              svc_ok,
  output logic              peek_valid,
  output logic              peek_inserv,
  output logic [AW-1:0]     peek_addr,
  output logic [SIZE_W-1:0] peek_size,
  output logic [ORD_W-1:0]  peek_ord
);
  logic [DEPTH-1:0]  valid_q, inserv_q;
  logic [AW-1:0]     addr_q [DEPTH];
  logic [SIZE_W-1:0] size_q [DEPTH];
  logic [ORD_W-1:0]  ord_q  [DEPTH];

  // lowest free entry, count of pending entries, lookups
  always_comb begin
    has_slot    = 1'b0;
    slot_idx    = '0;
    pend_cnt    = '0;
    svc_ok      = 1'b0;
    peek_valid  = 1'b0;
    peek_inserv = 1'b0;
    peek_addr   = '0;
    peek_size   = '0;
    peek_ord    = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        has_slot = 1'b1;
        slot_idx = IW'(i);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (valid_q[i] && !inserv_q[i]) pend_cnt = pend_cnt + CW'(1);
      if (svc_en && svc_idx == IW'(i) && valid_q[i] && !inserv_q[i]) svc_ok = 1'b1;
      if (peek_idx == IW'(i)) begin
        peek_valid  = valid_q[i];
        peek_inserv = inserv_q[i];
        peek_addr   = addr_q[i];
        peek_size   = size_q[i];
        peek_ord    = ord_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      inserv_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        addr_q[i] <= '0;
        size_q[i] <= '0;
        ord_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (free_en && free_idx == IW'(i)) begin
          valid_q[i]  <= 1'b0;
          inserv_q[i] <= 1'b0;
        end
        if (svc_ok && svc_idx == IW'(i)) inserv_q[i] <= 1'b1;
        if (alloc_en && slot_idx == IW'(i)) begin
          valid_q[i]  <= 1'b1;
          inserv_q[i] <= 1'b0;
          addr_q[i]   <= alloc_addr;
          size_q[i]   <= alloc_size;
          ord_q[i]    <= alloc_ord;
        end
      end
    end
  end
endmodule

// File: rtl/mwa_stall_track.sv
module mwa_stall_track #(
  parameter int NC    = 2,
  parameter int CNT_W = 16,
  localparam int SW   = (NC > 1) ? $clog2(NC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NC-1:0]    set_vec,
  input  logic [NC-1:0]    clr_vec,
  input  logic [SW-1:0]    stat_sel,
  output logic [NC-1:0]    mask,
  output logic [CNT_W-1:0] stat_events,
  output logic [CNT_W-1:0] stat_cycles
);
  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] events_q [NC];
  logic [CNT_W-1:0] cycles_q [NC];
  logic [CNT_W-1:0] start_q  [NC];

  always_ff @(posedge clk) begin
    if (rst) now_q <= '0;
    else     now_q <= now_q + CNT_W'(1);
  end

  for (genvar c = 0; c < NC; c++) begin : g_cause
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[c]     <= 1'b0;
        events_q[c] <= '0;
        cycles_q[c] <= '0;
        start_q[c]  <= '0;
      end else if (set_vec[c] && !mask[c]) begin
        mask[c]     <= 1'b1;
        events_q[c] <= events_q[c] + CNT_W'(1);
        start_q[c]  <= now_q;
      end else if (clr_vec[c] && mask[c]) begin
        mask[c]     <= 1'b0;
        cycles_q[c] <= cycles_q[c] + (now_q - start_q[c]);
      end
    end
  end

  always_comb begin
    stat_events = '0;
    stat_cycles = '0;
    for (int c = 0; c < NC; c++) begin
      if (stat_sel == SW'(c)) begin
        stat_events = events_q[c];
        stat_cycles = cycles_q[c];
      end
    end
  end
endmodule

// File: rtl/miss_wb_alloc.sv
module miss_wb_alloc
  import mwa_pkg::*;
#(
  parameter int AW         = 16,
  parameter int SIZE_W     = 8,
  parameter int BLK_BYTES  = 16,
  parameter int MISS_DEPTH = 4,
  parameter int WB_DEPTH   = 2,
  parameter int ORD_W      = 8,
  parameter int CNT_W      = 16,
  parameter int MAX_MISSES = 3,
  localparam int MAXD      = (MISS_DEPTH > WB_DEPTH) ? MISS_DEPTH : WB_DEPTH,
  localparam int IW        = (MAXD > 1) ? $clog2(MAXD) : 1,
  localparam int CW        = $clog2(MAXD + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  input  logic [1:0]        alloc_kind,
  input  logic [AW-1:0]     alloc_addr,
  input  logic [SIZE_W-1:0] alloc_size,
  input  logic              alloc_want_bus,
  output logic [IW-1:0]     grant_idx,
  output logic [ORD_W-1:0]  grant_order,
  input  logic              retry_wait,
  output logic              bus_req_valid,
  output logic              bus_req_cause,
  input  logic              svc_valid,
  input  logic              svc_pool,
  input  logic [IW-1:0]     svc_idx,
  input  logic              free_valid,
  input  logic              free_pool,
  input  logic [IW-1:0]     free_idx,
  input  logic              peek_pool,
  input  logic [IW-1:0]     peek_idx,
  output logic              peek_valid,
  output logic              peek_inserv,
  output logic [AW-1:0]     peek_addr,
  output logic [SIZE_W-1:0] peek_size,
  output logic [ORD_W-1:0]  peek_order,
  output logic [1:0]        stall_mask,
  output logic              cpu_stall,
  input  logic              stat_sel,
  output logic [CNT_W-1:0]  stat_events,
  output logic [CNT_W-1:0]  stat_cycles,
  output logic [CNT_W-1:0]  miss_count,
  output logic              miss_limit
);
  localparam logic [AW-1:0] BLK_MASK = ~AW'(BLK_BYTES - 1);

  alloc_kind_e       kind;
  logic              pool_sel, kind_ok, fire;
  logic [AW-1:0]     eff_addr;
  logic [SIZE_W-1:0] eff_size;
  logic [ORD_W-1:0]  ord_q;

  logic              has_slot [NUM_POOLS];
  logic [IW-1:0]     slot_idx [NUM_POOLS];
  logic [CW-1:0]     pend_cnt [NUM_POOLS];
  logic              svc_ok   [NUM_POOLS];
  logic              pk_valid [NUM_POOLS];
  logic              pk_inserv[NUM_POOLS];
  logic [AW-1:0]     pk_addr  [NUM_POOLS];
  logic [SIZE_W-1:0] pk_size  [NUM_POOLS];
  logic [ORD_W-1:0]  pk_ord   [NUM_POOLS];
  logic [NUM_POOLS-1:0] set_vec, clr_vec;

  // request decode: target pool and stored form of address and size
  always_comb begin
    kind     = alloc_kind_e'(alloc_kind);
    pool_sel = (kind == KIND_WRITE);
    kind_ok  = (kind != KIND_NONE);
    if (kind == KIND_MISS) begin
      eff_addr = alloc_addr & BLK_MASK;
      eff_size = SIZE_W'(BLK_BYTES);
    end else begin
      eff_addr = alloc_addr;
      eff_size = alloc_size;
    end
  end

  assign alloc_ready = kind_ok && has_slot[pool_sel];
  assign fire        = alloc_valid && alloc_ready;
  assign grant_idx   = slot_idx[pool_sel];
  assign grant_order = ord_q;

  for (genvar p = 0; p < NUM_POOLS; p++) begin : g_pool
    localparam int PD = (p == POOL_MISS) ? MISS_DEPTH : WB_DEPTH;
    logic a_en, s_en, f_en;
    int   nxt;
    assign a_en = fire && (pool_sel == 1'(p));
    assign s_en = svc_valid && (svc_pool == 1'(p));
    assign f_en = free_valid && (free_pool == 1'(p));

    mwa_entry_pool #(
      .DEPTH(PD), .AW(AW), .SIZE_W(SIZE_W), .ORD_W(ORD_W), .IW(IW), .CW(CW)
    ) u_pool (
      .clk(clk), .rst(rst),
      .alloc_en(a_en), .alloc_addr(eff_addr), .alloc_size(eff_size), .alloc_ord(ord_q),
      .svc_en(s_en), .svc_idx(svc_idx),
      .free_en(f_en), .free_idx(free_idx),
      .peek_idx(peek_idx),
      .has_slot(has_slot[p]), .slot_idx(slot_idx[p]), .pend_cnt(pend_cnt[p]),
      .svc_ok(svc_ok[p]),
      .peek_valid(pk_valid[p]), .peek_inserv(pk_inserv[p]), .peek_addr(pk_addr[p]),
      .peek_size(pk_size[p]), .peek_ord(pk_ord[p])
    );

    // saturation transitions: pending count after this edge
    always_comb begin
      nxt        = int'(pend_cnt[p]) + int'(a_en) - int'(svc_ok[p]);
      set_vec[p] = a_en && (nxt == PD);
      clr_vec[p] = svc_ok[p] && (int'(pend_cnt[p]) == PD) && (nxt < PD);
    end
  end

  mwa_stall_track #(.NC(NUM_POOLS), .CNT_W(CNT_W)) u_stall (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .stat_sel(stat_sel), .mask(stall_mask),
    .stat_events(stat_events), .stat_cycles(stat_cycles)
  );
  assign cpu_stall = |stall_mask;

  assign peek_valid  = pk_valid[peek_pool];
  assign peek_inserv = pk_inserv[peek_pool];
  assign peek_addr   = pk_addr[peek_pool];
  assign peek_size   = pk_size[peek_pool];
  assign peek_order  = pk_ord[peek_pool];

  always_ff @(posedge clk) begin
    if (rst) begin
      ord_q         <= '0;
      bus_req_valid <= 1'b0;
      bus_req_cause <= 1'b0;
      miss_count    <= '0;
    end else begin
      bus_req_valid <= fire && alloc_want_bus && !retry_wait;
      bus_req_cause <= pool_sel;
      if (fire) ord_q <= ord_q + ORD_W'(1);
      if (fire && kind == KIND_MISS && miss_count != CNT_W'(MAX_MISSES))
        miss_count <= miss_count + CNT_W'(1);
    end
  end
  assign miss_limit = (miss_count >= CNT_W'(MAX_MISSES));
endmodule

// File: rtl/mwa_checker.sv
module mwa_checker #(
  parameter int ORD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [1:0]       alloc_kind,
  input logic             alloc_want_bus,
  input logic             retry_wait,
  input logic             bus_req_valid,
  input logic             svc_valid,
  input logic [1:0]       stall_mask,
  input logic             cpu_stall,
  input logic             miss_limit,
  input logic [ORD_W-1:0] ord_q
);
  logic fire;
  assign fire = alloc_valid && alloc_ready;

  assert_bus_after_fire_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_valid) |-> $past(fire && alloc_want_bus && !retry_wait));

  assert_refused_keeps_order_R6: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid && !alloc_ready) |=> $stable(ord_q));

  assert_order_step_R5: assert property (@(posedge clk) disable iff (rst)
    fire |=> (ord_q == $past(ord_q) + ORD_W'(1)));

  assert_kind3_refused_R4: assert property (@(posedge clk) disable iff (rst)
    (alloc_kind == 2'd3) |-> !alloc_ready);

  assert_limit_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    miss_limit |=> miss_limit);

  assert_unstall_needs_svc_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_stall) |-> $past(svc_valid));

  assert_stall_bit_needs_fire_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(stall_mask[0]) || $rose(stall_mask[1])) |-> $past(fire));
endmodule

bind miss_wb_alloc mwa_checker #(.ORD_W(ORD_W)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .alloc_kind(alloc_kind), .alloc_want_bus(alloc_want_bus), .retry_wait(retry_wait),
  .bus_req_valid(bus_req_valid), .svc_valid(svc_valid), .stall_mask(stall_mask),
  .cpu_stall(cpu_stall), .miss_limit(miss_limit), .ord_q(ord_q)
);

// File: tb/sim_miss_wb_alloc.sv
`timescale 1ns/1ps
module sim_miss_wb_alloc;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic alloc_valid = 0, alloc_want_bus = 0, retry_wait = 0;
  logic [1:0] alloc_kind = 0;
  logic [15:0] alloc_addr = 0;
  logic [7:0] alloc_size = 0;
  logic svc_valid = 0, svc_pool = 0, free_valid = 0, free_pool = 0;
  logic [1:0] svc_idx = 0, free_idx = 0, peek_idx = 0;
  logic peek_pool = 0, stat_sel = 0;
  logic alloc_ready, bus_req_valid, bus_req_cause, peek_valid, peek_inserv;
  logic [1:0] grant_idx, stall_mask;
  logic [7:0] grant_order, peek_order, peek_size;
  logic [15:0] peek_addr, stat_events, stat_cycles, miss_count;
  logic cpu_stall, miss_limit;

  miss_wb_alloc u0 (.*);

  int checks = 0, errors = 0, tb_cyc = 0;
  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;   logic [15:0] addr; logic [7:0] size;
    logic        want;   logic retry;       logic exp_rdy;
    logic        pool;   logic [1:0] idx;   logic [15:0] eaddr;
    logic [7:0]  esize;  logic [7:0] eord;  logic ebus;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 16'h1237, 8'd4, 1'b1, 1'b0, 1'b1, 1'b0, 2'd0, 16'h1230, 8'd16, 8'd0, 1'b1}, // R2
    '{2'd1, 16'h2005, 8'd3, 1'b1, 1'b0, 1'b1, 1'b1, 2'd0, 16'h2005, 8'd3,  8'd1, 1'b1}, // R3
    '{2'd2, 16'h3009, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 16'h3009, 8'd2,  8'd2, 1'b0}, // R4
    '{2'd1, 16'h4444, 8'd8, 1'b1, 1'b1, 1'b1, 1'b1, 2'd1, 16'h4444, 8'd8,  8'd3, 1'b0}, // R9 retry
    '{2'd1, 16'h5000, 8'd1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 16'h0000, 8'd0,  8'd0, 1'b0}, // R6 full
    '{2'd3, 16'h6000, 8'd1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 8'd0,  8'd0, 1'b0}, // R4 kind 3
    '{2'd0, 16'h00FF, 8'd1, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 16'h00F0, 8'd16, 8'd4, 1'b1}  // R2 R5
  };

  logic g_rdy, g_bus, g_cause;
  logic [1:0] g_idx;
  logic [7:0] g_ord;

  task automatic do_alloc(input logic [1:0] k, input logic [15:0] a, input logic [7:0] s,
                          input logic w, input logic r);
    @(negedge clk);
    alloc_kind = k; alloc_addr = a; alloc_size = s; alloc_want_bus = w; retry_wait = r;
    alloc_valid = 1'b1;
    #1;
    g_rdy = alloc_ready; g_idx = grant_idx; g_ord = grant_order;
    @(posedge clk);
    @(negedge clk);
    g_bus = bus_req_valid; g_cause = bus_req_cause;
    alloc_valid = 1'b0; retry_wait = 1'b0;
  endtask

  task automatic probe_ready(input logic [1:0] k, output logic rdy);
    alloc_kind = k; #1; rdy = alloc_ready;
  endtask

  task automatic peek(input logic p, input logic [1:0] i);
    peek_pool = p; peek_idx = i; #1;
  endtask

  task automatic mark(input logic p, input logic [1:0] i);
    @(negedge clk); svc_valid = 1; svc_pool = p; svc_idx = i;
    @(posedge clk); @(negedge clk); svc_valid = 0;
  endtask

  task automatic release_entry(input logic p, input logic [1:0] i);
    @(negedge clk); free_valid = 1; free_pool = p; free_idx = i;
    @(posedge clk); @(negedge clk); free_valid = 0;
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic r;
    int blk_at, svc_at;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R1 reset state
    chk(stall_mask == 0 && !cpu_stall, "R1", "mask", stall_mask, 0);
    chk(miss_count == 0 && !miss_limit, "R1", "misses", miss_count, 0);
    chk(grant_order == 0, "R1", "order", grant_order, 0);
    probe_ready(2'd0, r); chk(r, "R1", "ready k0", r, 1);
    probe_ready(2'd1, r); chk(r, "R1", "ready k1", r, 1);
    probe_ready(2'd2, r); chk(r, "R1", "ready k2", r, 1);
    peek(1'b0, 2'd0); chk(!peek_valid, "R1", "entry", peek_valid, 0);
    stat_sel = 0; #1; chk(stat_events == 0 && stat_cycles == 0, "R1", "stats", stat_events, 0);

    blk_at = 0;
    for (int v = 0; v < 7; v++) begin
      do_alloc(VECS[v].kind, VECS[v].addr, VECS[v].size, VECS[v].want, VECS[v].retry);
      if (v == 3) blk_at = tb_cyc;
      chk(g_rdy == VECS[v].exp_rdy, "R6", $sformatf("ready v%0d", v), g_rdy, VECS[v].exp_rdy);
      chk(g_bus == VECS[v].ebus, "R9", $sformatf("bus v%0d", v), g_bus, VECS[v].ebus);
      if (VECS[v].exp_rdy) begin
        chk(g_idx == VECS[v].idx, "R12", $sformatf("idx v%0d", v), g_idx, VECS[v].idx);
        chk(g_ord == VECS[v].eord, "R5", $sformatf("grant ord v%0d", v), g_ord, VECS[v].eord);
        if (VECS[v].ebus) chk(g_cause == VECS[v].pool, "R9", "cause", g_cause, VECS[v].pool);
        peek(VECS[v].pool, VECS[v].idx);
        chk(peek_valid && !peek_inserv, "R2", $sformatf("stored v%0d", v), peek_valid, 1);
        chk(peek_addr == VECS[v].eaddr, "R2", $sformatf("addr v%0d", v), peek_addr, VECS[v].eaddr);
        chk(peek_size == VECS[v].esize, "R3", $sformatf("size v%0d", v), peek_size, VECS[v].esize);
        chk(peek_order == VECS[v].eord, "R5", $sformatf("ord v%0d", v), peek_order, VECS[v].eord);
      end
    end
    // R6 refused offers left order at 5 and pool 1 unchanged
    chk(grant_order == 8'd5, "R6", "order after refusals", grant_order, 5);
    chk(miss_count == 2, "R11", "miss count", miss_count, 2);
    chk(stall_mask == 2'b10 && cpu_stall, "R7", "write pool stall", stall_mask, 2);
    stat_sel = 1; #1; chk(stat_events == 1, "R10", "events wr", stat_events, 1);

    repeat (3) @(negedge clk);
    mark(1'b1, 2'd0); svc_at = tb_cyc;
    chk(stall_mask == 0 && !cpu_stall, "R8", "unblock", stall_mask, 0);
    stat_sel = 1; #1;
    chk(stat_cycles == 16'(svc_at - blk_at), "R10", "blocked cycles", stat_cycles, svc_at - blk_at);
    probe_ready(2'd1, r); chk(!r, "R6", "no slot after svc", r, 0);
    peek(1'b1, 2'd0); chk(peek_valid && peek_inserv, "R8", "in service", peek_inserv, 1);
    mark(1'b1, 2'd0);
    chk(stall_mask == 0, "R8", "repeat mark ignored", stall_mask, 0);
    peek(1'b1, 2'd0); chk(peek_valid && peek_order == 1, "R8", "entry kept", peek_order, 1);

    release_entry(1'b1, 2'd0);
    probe_ready(2'd1, r); chk(r, "R12", "ready after free", r, 1);
    do_alloc(2'd1, 16'h7777, 8'd5, 1'b0, 1'b0);
    chk(g_idx == 0 && g_ord == 5, "R12", "reuse idx0", g_idx, 0);
    chk(stall_mask == 2'b10, "R7", "write resaturated", stall_mask, 2);
    stat_sel = 1; #1; chk(stat_events == 2, "R10", "events wr 2", stat_events, 2);

    do_alloc(2'd0, 16'h888C, 8'd1, 1'b1, 1'b0);
    chk(g_idx == 3 && g_ord == 6, "R5", "miss idx3", g_ord, 6);
    chk(miss_count == 3 && miss_limit, "R11", "limit", miss_count, 3);
    chk(stall_mask == 2'b11, "R7", "both stalled", stall_mask, 3);
    probe_ready(2'd2, r); chk(!r, "R6", "miss pool full", r, 0);
    mark(1'b0, 2'd3);
    chk(stall_mask == 2'b10, "R8", "miss unblock", stall_mask, 2);
    release_entry(1'b0, 2'd1);
    do_alloc(2'd0, 16'h9991, 8'd1, 1'b0, 1'b0);
    chk(g_rdy && g_idx == 1, "R12", "lowest free", g_idx, 1);
    chk(stall_mask == 2'b10, "R7", "not resaturated", stall_mask, 2);
    chk(miss_count == 3 && miss_limit, "R11", "saturated count", miss_count, 3);

    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    chk(stall_mask == 0 && miss_count == 0 && !miss_limit, "R1", "re-reset", stall_mask, 0);
    chk(grant_order == 0, "R1", "order re-reset", grant_order, 0);
    peek(1'b1, 2'd1); chk(!peek_valid, "R1", "pool emptied", peek_valid, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule